// File: doc/BRIEF.md
# SDRAM Bank Command Sequencer

This block sits between a memory controller's scheduling logic and the command pins of a four-bank synchronous DRAM. The user side presents one request at a time: load the mode register, open a row in a bank, close one bank, or close every bank. The block turns each request into the chip-select, row-strobe, column-strobe and write-enable pattern, together with the bank-select pair and the address bus. The pins are registered, so a command appears on them in the cycle after its request is accepted.

Each bank carries its own state: idle, open, or closing. A closing bank has a countdown that covers the precharge-to-activate wait. A separate timer blocks every command for the two cycles after a mode-register load. A request is accepted only in a cycle where it can be issued legally. Otherwise `req_ready` stays low and the user holds the request. A row-open request to a bank that is already open is consumed, but it puts no command on the pins and raises an error pulse instead. When nothing is issued, the pins carry a no-operation command.

Top module: `sdram_cmd_seq`

## Requirements
- R1: During and right after reset, the pins show NOP, `sd_ba` and `sd_addr` are zero and `act_err` is low. A mode-load request is ready and a row-open request is not.
- R2: `req_op` encodes 0 as mode load, 1 as row open, 2 as single-bank close and 3 as all-bank close. In the cycle after acceptance the pins {cs_n,ras_n,cas_n,we_n} show 0000 for mode load, 0011 for row open and 0010 for either close. NOP is 0111.
- R3: On a mode load, `sd_ba` carries `req_bank` and `sd_addr` carries `req_row`. A mode load is accepted only when no bank is open and no bank is still inside its precharge wait.
- R4: For the two cycles after a mode load is accepted, `req_ready` is low for every operation and the pins show NOP.
- R5: A row-open request is never accepted until a mode load has been accepted since reset.
- R6: On a row open, `sd_ba` is `req_bank` and `sd_addr` is `req_row`, and that bank becomes open.
- R7: On a single-bank close, `sd_ba` is `req_bank` and `sd_addr` is zero, with bit 10 low. Closing a bank that is idle is legal.
- R8: On an all-bank close, `sd_addr` bit 10 is high and all other address bits are zero, and every bank begins its precharge wait.
- R9: A row open to a bank is accepted no earlier than TRP cycles after that bank's close was accepted. The default TRP is 3, and the request is accepted exactly at that boundary.
- R10: A row open to a bank that is already open is accepted and no command is issued. The pins show NOP and `act_err` is high for one cycle.
- R11: `req_ready` reflects the request's legality whether or not `req_valid` is high. A cycle with no accepted request leaves NOP on the pins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation code (R2) |
| req_bank | input | BANK_W | Target bank; upper mode bits for a mode load |
| req_row | input | ROW_W | Row address, or lower mode bits for a mode load |
| req_ready | output | 1 | Request can be issued this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_addr | output | ROW_W | Address bus |
| act_err | output | 1 | One-cycle pulse for a row open to an open bank |

## Verification
Two timers can expire in the same cycle as a new request: a bank's precharge wait, and the blocking window after a mode load. The stimulus table places a row open in exactly the cycle a bank's wait reaches TRP, having already tried it one and two cycles early. It also issues an all-bank close and then repeats a mode load every cycle until the last bank's wait runs out. That mode load is then followed at once by requests during its own two-cycle window. Each of these boundary cycles is judged twice: by the `req_ready` level before the edge, and by the pin pattern one cycle later.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [1:0] {
    OP_MODE   = 2'd0,
    OP_OPEN   = 2'd1,
    OP_CLOSE  = 2'd2,
    OP_CLOSEA = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_CLOSE = 2'd2
  } bank_st_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PIN_NOP  = 4'b0111;
  localparam logic [3:0] PIN_MODE = 4'b0000;
  localparam logic [3:0] PIN_OPEN = 4'b0011;
  localparam logic [3:0] PIN_PRE  = 4'b0010;

  // address bit that widens a close to every bank
  localparam int ALL_BIT = 10;

  function automatic logic [3:0] pins_for(op_e op);
    case (op)
      OP_MODE:  return PIN_MODE;
      OP_OPEN:  return PIN_OPEN;
      default:  return PIN_PRE;
    endcase
  endfunction

  // a bank may be opened (or join a mode load) when idle or when its wait is spent
  function automatic logic bank_free(bank_st_e st, logic wait_spent);
    return (st == BK_IDLE) || (st == BK_CLOSE && wait_spent);
  endfunction

endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_seq_pkg::*;
#(
  parameter int TRP   = 3,
  parameter int CNT_W = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     open_i,
  input  logic     close_i,
  output bank_st_e state_o,
  output logic     free_o,
  output logic     open_o
);

  localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(TRP - 1);

  bank_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             spent;

  assign spent = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else if (close_i) begin
      st_q  <= BK_CLOSE;
      cnt_q <= WAIT_LOAD;
    end else if (open_i) begin
      st_q  <= BK_OPEN;
    end else if (st_q == BK_CLOSE) begin
      if (spent) st_q <= BK_IDLE;
      else       cnt_q <= cnt_q - 1'b1;
    end
  end

  assign state_o = st_q;
  assign free_o  = bank_free(st_q, spent);
  assign open_o  = (st_q == BK_OPEN);

endmodule

// File: rtl/sdram_mode_timer.sv
module sdram_mode_timer #(
  parameter int TMRD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic loaded_o
);

  localparam int TW = $clog2(TMRD + 1);

  logic [TW-1:0] cnt_q;
  logic          loaded_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      loaded_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= TW'(TMRD);
      loaded_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign busy_o   = (cnt_q != '0);
  assign loaded_o = loaded_q;

endmodule

// File: rtl/sdram_req_gate.sv
module sdram_req_gate
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int BANKS  = 4
) (
  input  logic              valid_i,
  input  op_e               op_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [BANKS-1:0]  free_i,
  input  logic [BANKS-1:0]  open_i,
  input  logic              loaded_i,
  input  logic              mrd_busy_i,
  output logic              ready_o,
  output logic              fire_mode_o,
  output logic              fire_issue_o,
  output logic              fire_err_o,
  output logic [BANKS-1:0]  open_mask_o,
  output logic [BANKS-1:0]  close_mask_o
);

  logic legal, fire, tgt_open, tgt_free;

  assign tgt_open = open_i[bank_i];
  assign tgt_free = free_i[bank_i];

  always_comb begin
    case (op_i)
      OP_MODE: legal = !mrd_busy_i && (&free_i);
      OP_OPEN: legal = !mrd_busy_i && loaded_i && (tgt_free || tgt_open);
      default: legal = !mrd_busy_i;
    endcase
  end

  assign ready_o = legal;
  assign fire    = valid_i && legal;

  assign fire_mode_o  = fire && (op_i == OP_MODE);
  assign fire_err_o   = fire && (op_i == OP_OPEN) && tgt_open;
  assign fire_issue_o = fire && !fire_err_o;

  always_comb begin
    open_mask_o  = '0;
    close_mask_o = '0;
    if (fire && op_i == OP_OPEN && !tgt_open) open_mask_o[bank_i] = 1'b1;
    if (fire && op_i == OP_CLOSE)             close_mask_o[bank_i] = 1'b1;
    if (fire && op_i == OP_CLOSEA)            close_mask_o = '1;
  end

endmodule

// File: rtl/sdram_pin_drv.sv
module sdram_pin_drv
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic              err_i,
  input  op_e               op_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic [3:0]        pins_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic              err_o
);

  logic [ROW_W-1:0] addr_d;

  always_comb begin
    addr_d = row_i;
    if (op_i == OP_CLOSE || op_i == OP_CLOSEA) begin
      addr_d          = '0;
      addr_d[ALL_BIT] = (op_i == OP_CLOSEA);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pins_o <= PIN_NOP;
      ba_o   <= '0;
      addr_o <= '0;
      err_o  <= 1'b0;
    end else begin
      err_o <= err_i;
      if (issue_i) begin
        pins_o <= pins_for(op_i);
        ba_o   <= bank_i;
        addr_o <= addr_d;
      end else begin
        pins_o <= PIN_NOP;
        ba_o   <= '0;
        addr_o <= '0;
      end
    end
  end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int TRP    = 3,
  parameter int TMRD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  output logic              req_ready,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic              act_err
);

  localparam int BANKS = 1 << BANK_W;
  localparam int CNT_W = $clog2(TRP) + 1;

  op_e              op;
  logic [BANKS-1:0] bank_free_w, bank_open_w, open_mask, close_mask;
  bank_st_e         bank_st [BANKS];
  logic             mrd_busy, mode_loaded;
  logic             fire_mode, fire_issue, fire_err;
  logic [3:0]       pins;

  assign op = op_e'(req_op);

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      sdram_bank_track #(.TRP(TRP), .CNT_W(CNT_W)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_i  (open_mask[b]),
        .close_i (close_mask[b]),
        .state_o (bank_st[b]),
        .free_o  (bank_free_w[b]),
        .open_o  (bank_open_w[b])
      );
    end
  endgenerate

  sdram_mode_timer #(.TMRD(TMRD)) u_mrd (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (fire_mode),
    .busy_o   (mrd_busy),
    .loaded_o (mode_loaded)
  );

  sdram_req_gate #(.BANK_W(BANK_W), .BANKS(BANKS)) u_gate (
    .valid_i      (req_valid),
    .op_i         (op),
    .bank_i       (req_bank),
    .free_i       (bank_free_w),
    .open_i       (bank_open_w),
    .loaded_i     (mode_loaded),
    .mrd_busy_i   (mrd_busy),
    .ready_o      (req_ready),
    .fire_mode_o  (fire_mode),
    .fire_issue_o (fire_issue),
    .fire_err_o   (fire_err),
    .open_mask_o  (open_mask),
    .close_mask_o (close_mask)
  );

  sdram_pin_drv #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue_i (fire_issue),
    .err_i   (fire_err),
    .op_i    (op),
    .bank_i  (req_bank),
    .row_i   (req_row),
    .pins_o  (pins),
    .ba_o    (sd_ba),
    .addr_o  (sd_addr),
    .err_o   (act_err)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int TRP    = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [3:0]              pins,
  input logic [BANK_W-1:0]       ba,
  input logic [ROW_W-1:0]        addr,
  input logic                    err,
  input logic                    mode_loaded,
  input logic                    fire_mode,
  input logic                    fire_issue,
  input logic                    fire_err,
  input logic [(1<<BANK_W)-1:0]  bank_free_w
);

  localparam int BANKS = 1 << BANK_W;
  localparam int SW    = $clog2(TRP + 1) + 1;

  p_quiet_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_issue |=> (pins == PIN_NOP));

  p_mode_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == PIN_MODE) |=> (pins == PIN_NOP) ##1 (pins == PIN_NOP));

  p_mode_idle_banks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_mode |-> (&bank_free_w));

  p_open_after_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == PIN_OPEN) |-> mode_loaded);

  p_err_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire_err |=> (err && pins == PIN_NOP));

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_trp
      logic [SW-1:0] since_q;
      logic          hit;
      assign hit = (pins == PIN_PRE) && (addr[ALL_BIT] || ba == BANK_W'(b));
      always_ff @(posedge clk) begin
        if (!rst_n)                   since_q <= SW'(TRP);
        else if (hit)                 since_q <= SW'(1);
        else if (since_q < SW'(TRP))  since_q <= since_q + 1'b1;
      end
      p_trp_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == PIN_OPEN && ba == BANK_W'(b)) |-> (since_q >= SW'(TRP)));
    end
  endgenerate

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
  .BANK_W (BANK_W),
  .ROW_W  (ROW_W),
  .TRP    (TRP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pins        (pins),
  .ba          (sd_ba),
  .addr        (sd_addr),
  .err         (act_err),
  .mode_loaded (mode_loaded),
  .fire_mode   (fire_mode),
  .fire_issue  (fire_issue),
  .fire_err    (fire_err),
  .bank_free_w (bank_free_w)
);

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [1:0]  req_bank = 2'd0;
  logic [11:0] req_row = 12'd0;
  logic        req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, act_err;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sdram_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_bank(req_bank), .req_row(req_row), .req_ready(req_ready),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .act_err(act_err)
  );

  localparam logic [3:0] NOP = 4'b0111, MRS = 4'b0000, ACT = 4'b0011, PRE = 4'b0010;

  typedef struct packed {
    logic        v;
    logic [1:0]  op;
    logic [1:0]  bk;
    logic [11:0] row;
    logic        rdy;
    logic [3:0]  pins;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic        err;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd1, 2'd0, 12'h005, 1'b0, NOP, 2'd0, 12'h000, 1'b0, 4'd5},  // R5 open before mode load
    '{1'b1, 2'd0, 2'd0, 12'h033, 1'b1, MRS, 2'd0, 12'h033, 1'b0, 4'd3},  // R3 R2 mode load
    '{1'b1, 2'd1, 2'd1, 12'h007, 1'b0, NOP, 2'd0, 12'h000, 1'b0, 4'd4},  // R4 gap cycle 1
    '{1'b1, 2'd2, 2'd0, 12'h000, 1'b0, NOP, 2'd0, 12'h000, 1'b0, 4'd4},  // R4 gap cycle 2
    '{1'b1, 2'd1, 2'd1, 12'h0AB, 1'b1, ACT, 2'd1, 12'h0AB, 1'b0, 4'd6},  // R6 open bank 1
    '{1'b1, 2'd0, 2'd0, 12'h011, 1'b0, NOP, 2'd0, 12'h000, 1'b0, 4'd3},  // R3 mode blocked by open bank
    '{1'b1, 2'd1, 2'd1, 12'h001, 1'b1, NOP, 2'd0, 12'h000, 1'b1, 4'd10}, // R10 reopen is an error
    '{1'b1, 2'd1, 2'd2, 12'hFFF, 1'b1, ACT, 2'd2, 12'hFFF, 1'b0, 4'd6},  // R6 open bank 2
    '{1'b1, 2'd2, 2'd1, 12'h5A5, 1'b1, PRE, 2'd1, 12'h000, 1'b0, 4'd7},  // R7 close bank 1
    '{1'b1, 2'd1, 2'd1, 12'h003, 1'b0, NOP, 2'd0, 12'h000, 1'b0, 4'd9},  // R9 one cycle after close
    '{1'b0, 2'd1, 2'd1, 12'h003, 1'b0, NOP, 2'd0, 12'h000, 1'b0, 4'd11}, // R11 ready shown without valid
    '{1'b1, 2'd1, 2'd1, 12'h123, 1'b1, ACT, 2'd1, 12'h123, 1'b0, 4'd9},  // R9 exactly TRP later
    '{1'b1, 2'd3, 2'd3, 12'h0F0, 1'b1, PRE, 2'd3, 12'h400, 1'b0, 4'd8},  // R8 close all
    '{1'b1, 2'd0, 2'd2, 12'h022, 1'b0, NOP, 2'd0, 12'h000, 1'b0, 4'd3},  // R3 banks still waiting
    '{1'b1, 2'd0, 2'd2, 12'h022, 1'b0, NOP, 2'd0, 12'h000, 1'b0, 4'd3},  // R3 banks still waiting
    '{1'b1, 2'd0, 2'd2, 12'h022, 1'b1, MRS, 2'd2, 12'h022, 1'b0, 4'd3},  // R3 waits spent, mode load
    '{1'b0, 2'd1, 2'd0, 12'h000, 1'b0, NOP, 2'd0, 12'h000, 1'b0, 4'd4},  // R4 gap cycle 1
    '{1'b1, 2'd2, 2'd0, 12'h000, 1'b0, NOP, 2'd0, 12'h000, 1'b0, 4'd4},  // R4 gap cycle 2
    '{1'b1, 2'd2, 2'd0, 12'h000, 1'b1, PRE, 2'd0, 12'h000, 1'b0, 4'd7},  // R7 close of idle bank
    '{1'b0, 2'd1, 2'd3, 12'h009, 1'b1, NOP, 2'd0, 12'h000, 1'b0, 4'd11}  // R11 no valid, NOP
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_pins(input string tag, input logic [3:0] p, input logic [1:0] b,
                            input logic [11:0] a, input logic e);
    check({tag, " pins"}, {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {28'd0, p});
    check({tag, " ba"},   {30'd0, sd_ba}, {30'd0, b});
    check({tag, " addr"}, {20'd0, sd_addr}, {20'd0, a});
    check({tag, " err"},  {31'd0, act_err}, {31'd0, e});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_pins("R1 reset", NOP, 2'd0, 12'd0, 1'b0);
    req_op = 2'd1; #1;
    check("R1 open not ready", {31'd0, req_ready}, 32'd0);
    req_op = 2'd0; #1;
    check("R1 mode ready", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0)
        check_pins($sformatf("R%0d vec%0d", TBL[i-1].rq, i - 1),
                   TBL[i-1].pins, TBL[i-1].ba, TBL[i-1].addr, TBL[i-1].err);
      req_valid = TBL[i].v;
      req_op    = TBL[i].op;
      req_bank  = TBL[i].bk;
      req_row   = TBL[i].row;
      #1;
      check($sformatf("R%0d vec%0d ready", TBL[i].rq, i), {31'd0, req_ready}, {31'd0, TBL[i].rdy});
    end
    @(negedge clk);
    check_pins($sformatf("R%0d vec%0d", TBL[NV-1].rq, NV - 1),
               TBL[NV-1].pins, TBL[NV-1].ba, TBL[NV-1].addr, TBL[NV-1].err);

    // R10: an error pulse lasts one cycle once the request is withdrawn
    req_valid = 1'b1; req_op = 2'd1; req_bank = 2'd3; req_row = 12'h00C;
    @(negedge clk);
    check_pins("R6 open bank 3", ACT, 2'd3, 12'h00C, 1'b0);
    @(negedge clk);
    check_pins("R10 reopen bank 3", NOP, 2'd0, 12'd0, 1'b1);
    req_valid = 1'b0;
    @(negedge clk);
    check_pins("R10 pulse ends", NOP, 2'd0, 12'd0, 1'b0);

    // R1 R5: reset in mid-run forgets the mode load
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b1; req_op = 2'd1; req_bank = 2'd0; #1;
    check("R5 open blocked after reset", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    check_pins("R5 nothing issued", NOP, 2'd0, 12'd0, 1'b0);
    req_valid = 1'b0;
    finish_run();
  end

endmodule